// File: doc/BRIEF.md
# Reference Clock Stuck Detector

The detector supervises a set of reference clocks, two by default, and uses a separate feedback clock as its timebase. A fast system clock samples every reference and the feedback clock through multi-flop synchronizers. Within the system-clock domain the block tracks whether each reference has shown any transition since the last rising edge of the feedback clock. If a reference shows no transition for a whole feedback period, that reference is treated as dead. The detector then raises a flag for it, and the flag stays raised.

The flags feed a downstream clock selector. The selector also gets a one-cycle strobe for each reference at the moment that reference's flag goes high, so it can start a switchover without looking for the edge itself. The selector owns the clear pulse and sends it back to re-arm every flag at once. Detection runs continuously and has no mode input: the selector's switching policy has no effect on it.

Top module: `refclk_stuck_detector`

## Requirements
- R1: While the synchronous reset `rst` is high, every bit of `bad_o` and `fail_o` is 0 from the first clock edge on.
- R2: Bit i of `bad_o` (bit 0 belongs to `ref_in[0]`) goes from 0 to 1 only on the cycle after a synchronized rising edge of `fb_in`. It does so only when no transition of `ref_in[i]`, of either polarity, was sampled during the feedback period that edge closes. A reference held high and a reference held low are both flagged.
- R3: A set flag stays at 1 until `clr_in` is seen. This holds even if the reference starts toggling again.
- R4: A cycle with `clr_in` high makes every `bad_o` bit 0 on the next cycle, and the clear wins over a failure found in that same cycle. The feedback period in progress at the clear is excused, so a reference that is still stuck is flagged again only at a later feedback rising edge.
- R5: `fail_o[i]` is high for exactly the one cycle in which `bad_o[i]` goes from 0 to 1. It never stays high for two cycles and does not pulse while the flag remains set.
- R6: When all references stop together, all their flags are set on the same feedback edge, and their `fail_o` bits pulse in the same cycle.
- R7: After reset no flag can be set until one synchronized rising edge of `fb_in` has been seen. The first feedback period that is evaluated is the one that ends at the second such edge.
- R8: A reference whose longest gap between transitions is shorter than one feedback period is never flagged, even if it is slower than the feedback clock. A reference whose gaps are longer than one feedback period is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than every supervised clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | NUM_REFS | Asynchronous reference clocks under supervision |
| fb_in | input | 1 | Asynchronous feedback clock that sets the evaluation period |
| clr_in | input | 1 | One-cycle clear of all flags, issued by the selector |
| bad_o | output | NUM_REFS | Sticky dead-reference flags, bit i for `ref_in[i]` |
| fail_o | output | NUM_REFS | One-cycle strobe when the matching flag becomes set |

## Verification
The references are first run at several times the feedback rate. This shows that healthy clocks never raise a flag. The bench then stops one reference high and, separately, stops another low, which shows that both stuck levels are caught on their own channel only. Next, one reference is run slower than the feedback clock but with gaps shorter than a feedback period, and then with gaps longer than one. This separates "slow" from "dead". Finally, both references are stopped together, and a reset is applied with the feedback clock held. These last two patterns expose simultaneous setting, the excused window after a clear, and the arming rule after reset.

// File: rtl/sdet_pkg.sv
package sdet_pkg;

    // Registered state of one supervised reference
    typedef struct packed {
        logic toggled;   // a transition was sampled in the current feedback period
        logic bad;       // sticky dead flag
        logic fail;      // one-cycle strobe on the flag's rising edge
    } chan_state_t;

endpackage

// File: rtl/sdet_sync.sv
// Multi-flop synchronizer with an edge detector. RISE_ONLY picks the
// variant: rising edges only (feedback) or any transition (references).
module sdet_sync #(
    parameter int STAGES    = 2,
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic event_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        level_w;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], din};
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_w = st_q.pipe[STAGES-1];

    generate
        if (RISE_ONLY) begin : g_rise
            assign event_o = level_w & ~st_q.prev;
        end else begin : g_any
            assign event_o = level_w ^ st_q.prev;
        end
    endgenerate

endmodule

// File: rtl/sdet_chan.sv
// Per-reference activity tracker with a sticky flag and a fail strobe.
module sdet_chan
    import sdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_event,
    input  logic fb_rise,
    input  logic armed,
    input  logic clr,
    output logic bad,
    output logic fail
);
    chan_state_t st_d, st_q;
    logic        seen_w;
    logic        fault_w;

    always_comb begin
        // a transition in the closing cycle still counts for the period that ends there
        seen_w  = st_q.toggled | ref_event;
        fault_w = fb_rise & armed & ~seen_w;

        st_d      = st_q;
        st_d.bad  = clr ? 1'b0 : (st_q.bad | fault_w);
        st_d.fail = st_d.bad & ~st_q.bad;
        // a clear excuses the period in progress
        if (clr) begin
            st_d.toggled = 1'b1;
        end else if (fb_rise) begin
            st_d.toggled = 1'b0;
        end else begin
            st_d.toggled = seen_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bad  = st_q.bad;
    assign fail = st_q.fail;

    // R2: a flag only rises right after an armed feedback edge
    a_r2_set_at_fb_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(bad) |-> ($past(fb_rise) && $past(armed)));

    // R3: without a clear, a set flag holds
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        (bad && !clr) |=> bad);

    // R4: a clear always wins
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> !bad);

    // R5: the strobe marks the flag's rise and lasts one cycle
    a_r5_fail_marks_rise: assert property (@(posedge clk) disable iff (rst)
        fail |-> (bad && !$past(bad)));

    a_r5_fail_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fail |=> !fail);

endmodule

// File: rtl/refclk_stuck_detector.sv
module refclk_stuck_detector #(
    parameter int NUM_REFS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REFS-1:0] ref_in,
    input  logic                fb_in,
    input  logic                clr_in,
    output logic [NUM_REFS-1:0] bad_o,
    output logic [NUM_REFS-1:0] fail_o
);
    localparam int NUM_SIG = NUM_REFS + 1;
    localparam int FB_IDX  = NUM_REFS;

    typedef struct packed {
        logic armed;
    } top_state_t;

    logic [NUM_SIG-1:0] raw_w;
    logic [NUM_SIG-1:0] event_w;
    logic               fb_rise_w;
    top_state_t         st_d, st_q;

    assign raw_w = {fb_in, ref_in};

    generate
        for (genvar g = 0; g < NUM_SIG; g++) begin : g_sync
            sdet_sync #(
                .STAGES   (SYNC_STAGES),
                .RISE_ONLY(g == FB_IDX)
            ) u_sync (
                .clk    (clk),
                .rst    (rst),
                .din    (raw_w[g]),
                .event_o(event_w[g])
            );
        end
    endgenerate

    assign fb_rise_w = event_w[FB_IDX];

    // Arming: the first feedback rising edge after reset opens the first period
    always_comb begin
        st_d       = st_q;
        st_d.armed = st_q.armed | fb_rise_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_REFS; g++) begin : g_chan
            sdet_chan u_chan (
                .clk      (clk),
                .rst      (rst),
                .ref_event(event_w[g]),
                .fb_rise  (fb_rise_w),
                .armed    (st_q.armed),
                .clr      (clr_in),
                .bad      (bad_o[g]),
                .fail     (fail_o[g])
            );
        end
    endgenerate

    // R1: reset forces all outputs low
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (bad_o == '0 && fail_o == '0));

    // R7: nothing is flagged before the block is armed
    a_r7_quiet_until_armed: assert property (@(posedge clk) disable iff (rst)
        !st_q.armed |=> (bad_o == '0));

endmodule

// File: tb/refclk_stuck_detector_test.sv
module refclk_stuck_detector_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       fb  = 1'b0;
    logic [1:0] refs = 2'b00;
    logic [1:0] bad;
    logic [1:0] fail;

    always #5 clk = ~clk;

    refclk_stuck_detector uut (
        .clk   (clk),
        .rst   (rst),
        .ref_in(refs),
        .fb_in (fb),
        .clr_in(clr),
        .bad_o (bad),
        .fail_o(fail)
    );

    // stimulus generator: half periods in system cycles, 0 holds the level
    int   fb_half = 8;
    int   fb_cnt  = 0;
    logic fb_hold = 1'b0;
    int   ref_half [2] = '{3, 3};
    int   ref_cnt  [2] = '{0, 0};
    logic ref_hold [2] = '{1'b0, 1'b0};

    always @(negedge clk) begin
        if (fb_half == 0) fb = fb_hold;
        else if (fb_cnt + 1 >= fb_half) begin fb = ~fb; fb_cnt = 0; end
        else fb_cnt++;
        for (int i = 0; i < 2; i++) begin
            if (ref_half[i] == 0) refs[i] = ref_hold[i];
            else if (ref_cnt[i] + 1 >= ref_half[i]) begin refs[i] = ~refs[i]; ref_cnt[i] = 0; end
            else ref_cnt[i]++;
        end
    end

    // scoreboard
    typedef struct {
        logic [1:0] bad;
        int         f0;
        int         f1;
        string      tag;
    } exp_t;

    exp_t       q[$];
    int         checks = 0;
    int         errors = 0;
    int         pulses0 = 0;
    int         pulses1 = 0;
    logic [1:0] fail_prev = 2'b00;
    bit         both_same = 1'b0;

    always @(negedge clk) begin
        if (fail[0]) pulses0++;
        if (fail[1]) pulses1++;
        if (fail == 2'b11) both_same = 1'b1;
        if ((fail & fail_prev) != 2'b00) begin
            checks++; errors++;
            $display("FAIL R5 strobe wider than one cycle: fail=%b prev=%b expected no overlap", fail, fail_prev);
        end
        fail_prev = fail;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (bad !== e.bad || pulses0 != e.f0 || pulses1 != e.f1) begin
                errors++;
                $display("FAIL %s: bad=%b strobes=%0d/%0d expected bad=%b strobes=%0d/%0d",
                         e.tag, bad, pulses0, pulses1, e.bad, e.f0, e.f1);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_st(input logic [1:0] b, input int f0, input int f1, input string tag);
        exp_t e;
        @(posedge clk); #1;
        e.bad = b; e.f0 = f0; e.f1 = f1; e.tag = tag;
        q.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic set_ref(input int i, input int half, input logic lvl);
        @(posedge clk); #1;
        ref_half[i] = half; ref_hold[i] = lvl; ref_cnt[i] = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog expired: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        cyc(4);
        expect_st(2'b00, 0, 0, "R1 outputs low in reset");
        @(negedge clk); rst = 1'b0;

        cyc(80);
        expect_st(2'b00, 0, 0, "R2 healthy references not flagged");

        // ref0 stuck high
        set_ref(0, 0, 1'b1);
        cyc(50);
        expect_st(2'b01, 1, 0, "R2 ref0 stuck high flagged");
        cyc(48);
        expect_st(2'b01, 1, 0, "R5 single strobe while flag held");

        set_ref(0, 3, 1'b0);
        cyc(48);
        expect_st(2'b01, 1, 0, "R3 flag held after ref0 resumes");

        pulse_clr();
        expect_st(2'b00, 1, 0, "R4 clear drops flag");

        // ref1 stuck low
        set_ref(1, 0, 1'b0);
        cyc(50);
        expect_st(2'b10, 1, 1, "R2 ref1 stuck low flagged");
        pulse_clr();
        expect_st(2'b00, 1, 1, "R4 clear while ref1 still stuck");
        cyc(50);
        expect_st(2'b10, 1, 2, "R4 stuck ref1 flagged again with new strobe");

        set_ref(1, 3, 1'b0);
        cyc(10);
        pulse_clr();
        cyc(50);
        expect_st(2'b00, 1, 2, "R4 recovered ref1 stays clear");

        // slow but live vs too slow
        set_ref(0, 12, 1'b0);
        cyc(100);
        expect_st(2'b00, 1, 2, "R8 gaps shorter than feedback period not flagged");
        set_ref(0, 20, 1'b0);
        cyc(140);
        expect_st(2'b01, 2, 2, "R8 gaps longer than feedback period flagged");
        set_ref(0, 3, 1'b0);
        cyc(10);
        pulse_clr();
        cyc(40);
        expect_st(2'b00, 2, 2, "R8 restored ref0 clear");

        // both stop together
        both_same = 1'b0;
        @(posedge clk); #1;
        ref_half[0] = 0; ref_hold[0] = 1'b1;
        ref_half[1] = 0; ref_hold[1] = 1'b0;
        cyc(50);
        expect_st(2'b11, 3, 3, "R6 both stuck both flagged");
        checks++;
        if (!both_same) begin
            errors++;
            $display("FAIL R6 strobes not simultaneous: same_cycle=%0b expected 1", both_same);
        end

        // arming after reset with feedback held low
        @(posedge clk); #1;
        fb_half = 0; fb_hold = 1'b0;
        cyc(4);
        @(negedge clk); rst = 1'b1;
        cyc(3);
        @(negedge clk); rst = 1'b0;
        cyc(60);
        expect_st(2'b00, 3, 3, "R7 no flag without feedback edges");
        @(posedge clk); #1;
        fb_cnt = 0; fb_half = 8;
        cyc(16);
        expect_st(2'b00, 3, 3, "R7 arming edge does not evaluate");
        cyc(24);
        expect_st(2'b11, 4, 4, "R7 period closed by second edge evaluated");

        cyc(5);
        summary();
        $finish;
    end

endmodule